// File: doc/BRIEF.md
# Bidirectional Timer Counter Core

This block is the counting heart of an 8-bit timer. It keeps a count register that changes only on qualified timer ticks. Ticks are single-cycle enable pulses in the system clock domain. A 3-bit clock-select field picks one of seven tick enables supplied from outside, or stops the timer altogether. A small mode controller turns a 2-bit waveform-mode field into clear, count and direction strobes for the datapath.

The block has four counting modes: a free-running wrap, an up/down bounce, and two variants that count up to a compare value and then clear. Each mode has its own rule for raising the overflow flag. The flag serves as an interrupt request. It is cleared either by writing a one to the flag bit or by an interrupt-acknowledge pulse.

A processor-side port can read the count at any time, including while the timer is stopped. It can also write the count, and that write beats any clear or count in the same cycle. Top and bottom indications report when the count sits at the active upper limit or at zero.

Top module: `bdtimer_core`

## Requirements
- R1: Reset sets the count to 0, clears the overflow flag and sets the bounce direction to up. A count written after reset and then ticked in mode 1 therefore rises by one.
- R2: When clkSel is 0, no tick occurs and the count holds, whatever the tick lines carry. When clkSel is k (1..7), tickSrc[k-1] is the only qualifying tick, and the other tickSrc lines have no effect.
- R3: In mode 0 (waveMode 2'b00), each tick adds one, and 255 wraps to 0. The overflow flag is set on the tick that wraps 255 to 0.
- R4: In mode 1 (waveMode 2'b01), the count rises to 255 and then falls. A tick at 255 gives 254, and a tick at 0 gives 1. The overflow flag is set on every tick taken while the count is 0. Between the limits, the count keeps its last direction.
- R5: In mode 2 (waveMode 2'b10), a tick while the count equals cmpVal gives 0, and any other tick adds one, wrapping 255 to 0. The overflow flag is set only on a tick taken while the count is 255.
- R6: In mode 3 (waveMode 2'b11), the count follows the same sequence as in mode 2. The overflow flag is set on the tick that clears the count at cmpVal.
- R7: When regWrEn is high, the count takes regWrData on the next clock edge. A tick in that cycle is ignored: there is no count, no clear, no overflow set and no direction change.
- R8: countOut always shows the count register. The count can be written and read back while clkSel is 0.
- R9: topOut is high when the count equals the active top, which is 255 in modes 0 and 1 and cmpVal in modes 2 and 3. bottomOut is high when the count is 0.
- R10: The overflow flag clears when flagWrEn is high with flagWrData 1, or when intAck is high. Writing a 0 has no effect. A set in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkSel | input | 3 | Tick source select; 0 stops the timer |
| tickSrc | input | 7 | External tick enables for select values 1..7 |
| waveMode | input | 2 | Counting and overflow mode |
| cmpVal | input | 8 | Upper limit in modes 2 and 3 |
| regWrEn | input | 1 | Processor write strobe for the count |
| regWrData | input | 8 | Processor write data for the count |
| flagWrEn | input | 1 | Processor write strobe for the flag bit |
| flagWrData | input | 1 | Flag write data; 1 clears the flag |
| intAck | input | 1 | Interrupt acknowledge; clears the flag |
| countOut | output | 8 | Current count |
| topOut | output | 1 | Count is at the active top |
| bottomOut | output | 1 | Count is zero |
| ovfFlag | output | 1 | Overflow flag and interrupt request |

## Verification
The properties assume the following:
- Tick lines are plain single-cycle enables sampled on the system clock.
- Mode and compare inputs may change on any cycle.
- A processor write can coincide with a tick.

Checks that name a mode hold the mode condition only in the cycle where the tick is taken. No property relies on the mode being stable across cycles.

The stimulus changes all inputs half a period away from the active edge and holds them through the next edge. Each write, tick and acknowledge collision is a deliberate single-cycle event, so each property's antecedent is met cleanly. Flag-clear checks are run with the timer stopped, so a set and a clear cannot coincide by accident.

// File: rtl/bdtimer_pkg.sv
package bdtimer_pkg;

  typedef enum logic [1:0] {
    WM_WRAP      = 2'd0,
    WM_BOUNCE    = 2'd1,
    WM_CMP_WRAPF = 2'd2,
    WM_CMP_CLRF  = 2'd3
  } waveMode_e;

  // strobes from the mode controller to the datapath
  typedef struct packed {
    logic load;
    logic clear;
    logic count;
    logic down;
    logic setOvf;
  } ctrlStrb_t;

endpackage

// File: rtl/bdtimer_tick_sel.sv
module bdtimer_tick_sel #(
  parameter int SEL_W = 3,
  localparam int NUM_SRC = (1 << SEL_W) - 1
) (
  input  logic [SEL_W-1:0]   clkSel,
  input  logic [NUM_SRC-1:0] tickSrc,
  output logic               tick
);

  logic [NUM_SRC:0] srcExt;

  // select value 0 maps to a constant low: timer stopped
  assign srcExt[0] = 1'b0;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    assign srcExt[gi+1] = tickSrc[gi];
  end

  assign tick = srcExt[clkSel];

endmodule

// File: rtl/bdtimer_ctrl.sv
module bdtimer_ctrl
  import bdtimer_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      tick,
  input  logic [1:0] waveMode,
  input  logic      regWrEn,
  input  logic      atMax,
  input  logic      atZero,
  input  logic      atCmp,
  output ctrlStrb_t strb
);

  waveMode_e mode;
  logic      dirDown;
  logic      dirNext;
  logic      effDown;

  assign mode = waveMode_e'(waveMode);

  always_comb begin
    strb    = '0;
    effDown = 1'b0;
    dirNext = dirDown;
    if (regWrEn) begin
      // processor write overrides every counting action
      strb.load = 1'b1;
    end else if (tick) begin
      case (mode)
        WM_WRAP: begin
          strb.count  = 1'b1;
          strb.setOvf = atMax;
          dirNext     = 1'b0;
        end
        WM_BOUNCE: begin
          if (atMax)       effDown = 1'b1;
          else if (atZero) effDown = 1'b0;
          else             effDown = dirDown;
          strb.count  = 1'b1;
          strb.down   = effDown;
          strb.setOvf = atZero;
          dirNext     = effDown;
        end
        WM_CMP_WRAPF: begin
          if (atCmp) strb.clear = 1'b1;
          else       strb.count = 1'b1;
          strb.setOvf = atMax;
          dirNext     = 1'b0;
        end
        WM_CMP_CLRF: begin
          if (atCmp) strb.clear = 1'b1;
          else       strb.count = 1'b1;
          strb.setOvf = atCmp;
          dirNext     = 1'b0;
        end
        default: begin
          strb.count = 1'b0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) dirDown <= 1'b0;
    else       dirDown <= dirNext;
  end

endmodule

// File: rtl/bdtimer_datapath.sv
module bdtimer_datapath
  import bdtimer_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] cmpVal,
  input  logic             topIsCmp,
  input  logic             flagClr,
  output logic [CNT_W-1:0] count,
  output logic             atMax,
  output logic             atZero,
  output logic             atCmp,
  output logic             topOut,
  output logic             bottomOut,
  output logic             ovfFlag
);

  logic [CNT_W-1:0] countNext;

  assign atMax  = (count == CNT_MAX);
  assign atZero = (count == '0);
  assign atCmp  = (count == cmpVal);

  assign topOut    = topIsCmp ? atCmp : atMax;
  assign bottomOut = atZero;

  always_comb begin
    if (strb.load)       countNext = wrData;
    else if (strb.clear) countNext = '0;
    else if (strb.count) countNext = strb.down ? count - 1'b1 : count + 1'b1;
    else                 countNext = count;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count   <= '0;
      ovfFlag <= 1'b0;
    end else begin
      count <= countNext;
      // a set event outranks a clear in the same cycle
      if (strb.setOvf)  ovfFlag <= 1'b1;
      else if (flagClr) ovfFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/bdtimer_core.sv
module bdtimer_core
  import bdtimer_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3,
  localparam int NUM_SRC = (1 << SEL_W) - 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SEL_W-1:0]   clkSel,
  input  logic [NUM_SRC-1:0] tickSrc,
  input  logic [1:0]         waveMode,
  input  logic [CNT_W-1:0]   cmpVal,
  input  logic               regWrEn,
  input  logic [CNT_W-1:0]   regWrData,
  input  logic               flagWrEn,
  input  logic               flagWrData,
  input  logic               intAck,
  output logic [CNT_W-1:0]   countOut,
  output logic               topOut,
  output logic               bottomOut,
  output logic               ovfFlag
);

  ctrlStrb_t strb;
  logic      tick;
  logic      atMax;
  logic      atZero;
  logic      atCmp;
  logic      flagClr;

  assign flagClr = (flagWrEn & flagWrData) | intAck;

  bdtimer_tick_sel #(.SEL_W(SEL_W)) u_tick (
    .clkSel (clkSel),
    .tickSrc(tickSrc),
    .tick   (tick)
  );

  bdtimer_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .tick    (tick),
    .waveMode(waveMode),
    .regWrEn (regWrEn),
    .atMax   (atMax),
    .atZero  (atZero),
    .atCmp   (atCmp),
    .strb    (strb)
  );

  bdtimer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (regWrData),
    .cmpVal   (cmpVal),
    .topIsCmp (waveMode[1]),
    .flagClr  (flagClr),
    .count    (countOut),
    .atMax    (atMax),
    .atZero   (atZero),
    .atCmp    (atCmp),
    .topOut   (topOut),
    .bottomOut(bottomOut),
    .ovfFlag  (ovfFlag)
  );

endmodule

// File: rtl/bdtimer_core_chk.sv
module bdtimer_core_chk #(
  parameter int CNT_W = 8,
  parameter int SEL_W = 3,
  localparam int NUM_SRC = (1 << SEL_W) - 1,
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
  input logic               clk,
  input logic               rstN,
  input logic [SEL_W-1:0]   clkSel,
  input logic [NUM_SRC-1:0] tickSrc,
  input logic [1:0]         waveMode,
  input logic [CNT_W-1:0]   cmpVal,
  input logic               regWrEn,
  input logic [CNT_W-1:0]   regWrData,
  input logic               intAck,
  input logic [CNT_W-1:0]   countOut,
  input logic               ovfFlag
);

  logic tickSeen;

  always_comb begin
    tickSeen = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (clkSel == SEL_W'(i + 1) && tickSrc[i]) tickSeen = 1'b1;
    end
  end

  // R7
  wr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> countOut == $past(regWrData));

  // R2
  stopped_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clkSel == '0 && !regWrEn) |=> $stable(countOut));

  // R3
  wrap_inc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickSeen && waveMode == 2'd0 && !regWrEn)
      |=> countOut == CNT_W'($past(countOut) + 1'b1));

  // R3
  wrap_ovf_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickSeen && waveMode == 2'd0 && !regWrEn && countOut == CNT_MAX)
      |=> (ovfFlag && countOut == '0));

  // R4
  bounce_turn_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickSeen && waveMode == 2'd1 && !regWrEn && countOut == CNT_MAX)
      |=> countOut == CNT_MAX - 1'b1);

  // R6
  cmp_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tickSeen && waveMode == 2'd3 && !regWrEn && countOut == cmpVal)
      |=> (countOut == '0 && ovfFlag));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && clkSel == '0) |=> !ovfFlag);

endmodule

bind bdtimer_core bdtimer_core_chk #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .clkSel   (clkSel),
  .tickSrc  (tickSrc),
  .waveMode (waveMode),
  .cmpVal   (cmpVal),
  .regWrEn  (regWrEn),
  .regWrData(regWrData),
  .intAck   (intAck),
  .countOut (countOut),
  .ovfFlag  (ovfFlag)
);

// File: tb/test_bdtimer_core.sv
module test_bdtimer_core;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] clkSel = '0;
  logic [6:0] tickSrc = '0;
  logic [1:0] waveMode = '0;
  logic [7:0] cmpVal = '0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       flagWrEn = 1'b0;
  logic       flagWrData = 1'b0;
  logic       intAck = 1'b0;
  logic [7:0] countOut;
  logic       topOut;
  logic       bottomOut;
  logic       ovfFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] cnt;
    logic       flag;
    logic       top;
    logic       bot;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];

  // bench model state
  logic [7:0] mCnt = '0;
  logic       mDir = 1'b0;
  logic       mFlag = 1'b0;

  bdtimer_core i_bdtimer_core (
    .clk(clk), .rstN(rstN), .clkSel(clkSel), .tickSrc(tickSrc),
    .waveMode(waveMode), .cmpVal(cmpVal), .regWrEn(regWrEn),
    .regWrData(regWrData), .flagWrEn(flagWrEn), .flagWrData(flagWrData),
    .intAck(intAck), .countOut(countOut), .topOut(topOut),
    .bottomOut(bottomOut), .ovfFlag(ovfFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step(input logic [2:0] sel, input logic [6:0] src,
                      input logic [1:0] mode, input logic [7:0] cmp,
                      input logic wr, input logic [7:0] wd,
                      input logic fw, input logic fd, input logic ack,
                      input string tag);
    logic     tk;
    logic     setF;
    logic     eff;
    expItem_t it;
    @(negedge clk);
    clkSel = sel; tickSrc = src; waveMode = mode; cmpVal = cmp;
    regWrEn = wr; regWrData = wd; flagWrEn = fw; flagWrData = fd; intAck = ack;
    tk   = (sel != 0) && src[sel - 3'd1];
    setF = 1'b0;
    if (wr) begin
      mCnt = wd;
    end else if (tk) begin
      case (mode)
        2'd0: begin setF = (mCnt == 8'hFF); mCnt = mCnt + 8'd1; mDir = 1'b0; end
        2'd1: begin
          eff  = (mCnt == 8'hFF) ? 1'b1 : (mCnt == 8'h00) ? 1'b0 : mDir;
          setF = (mCnt == 8'h00);
          mCnt = eff ? mCnt - 8'd1 : mCnt + 8'd1;
          mDir = eff;
        end
        2'd2: begin setF = (mCnt == 8'hFF); mCnt = (mCnt == cmp) ? 8'd0 : mCnt + 8'd1; mDir = 1'b0; end
        default: begin setF = (mCnt == cmp); mCnt = (mCnt == cmp) ? 8'd0 : mCnt + 8'd1; mDir = 1'b0; end
      endcase
    end
    if (setF) mFlag = 1'b1;
    else if ((fw && fd) || ack) mFlag = 1'b0;
    it.cnt  = mCnt;
    it.flag = mFlag;
    it.top  = (mCnt == (mode[1] ? cmp : 8'hFF));
    it.bot  = (mCnt == 8'h00);
    it.tag  = tag;
    expQ.push_back(it);
  endtask

  task automatic ticks(input logic [1:0] mode, input logic [7:0] cmp,
                       input int n, input string tag);
    for (int i = 0; i < n; i++) step(3'd1, 7'h01, mode, cmp, 0, 8'd0, 0, 0, 0, tag);
  endtask

  task automatic wrCnt(input logic [1:0] mode, input logic [7:0] v, input string tag);
    step(3'd0, 7'h00, mode, 8'd0, 1, v, 0, 0, 0, tag);
  endtask

  // monitor: compare results one step after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (countOut !== e.cnt || ovfFlag !== e.flag || topOut !== e.top || bottomOut !== e.bot) begin
          errors++;
          $display("FAIL %s: cnt=%0d flag=%0b top=%0b bot=%0b expected cnt=%0d flag=%0b top=%0b bot=%0b",
                   e.tag, countOut, ovfFlag, topOut, bottomOut, e.cnt, e.flag, e.top, e.bot);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1 reset state
    checks++;
    if (countOut !== 8'd0 || ovfFlag !== 1'b0 || bottomOut !== 1'b1) begin
      errors++;
      $display("FAIL R1: cnt=%0d flag=%0b bot=%0b expected cnt=0 flag=0 bot=1",
               countOut, ovfFlag, bottomOut);
    end
    // R1 direction starts up
    wrCnt(2'd1, 8'd5, "R1");
    ticks(2'd1, 8'd0, 2, "R1");
    // R2 stopped with all lines active
    for (int i = 0; i < 4; i++) step(3'd0, 7'h7F, 2'd0, 8'd0, 0, 8'd0, 0, 0, 0, "R2");
    // R2 select 3: only line 2 counts
    step(3'd3, 7'h7B, 2'd0, 8'd0, 0, 8'd0, 0, 0, 0, "R2");
    step(3'd3, 7'h04, 2'd0, 8'd0, 0, 8'd0, 0, 0, 0, "R2");
    step(3'd7, 7'h3F, 2'd0, 8'd0, 0, 8'd0, 0, 0, 0, "R2");
    step(3'd7, 7'h40, 2'd0, 8'd0, 0, 8'd0, 0, 0, 0, "R2");
    // R3 wrap and overflow, R9 top at 255
    wrCnt(2'd0, 8'd252, "R3");
    ticks(2'd0, 8'd0, 6, "R3");
    // R10 write zero has no effect, write one clears
    step(3'd0, 7'h00, 2'd0, 8'd0, 0, 8'd0, 1, 0, 0, "R10");
    step(3'd0, 7'h00, 2'd0, 8'd0, 0, 8'd0, 1, 1, 0, "R10");
    // R10 set wins over ack
    wrCnt(2'd0, 8'd255, "R10");
    step(3'd1, 7'h01, 2'd0, 8'd0, 0, 8'd0, 0, 0, 1, "R10");
    step(3'd0, 7'h00, 2'd0, 8'd0, 0, 8'd0, 0, 0, 1, "R10");
    // R4 bounce at top then down to bottom
    wrCnt(2'd1, 8'd252, "R4");
    ticks(2'd1, 8'd0, 6, "R4");
    wrCnt(2'd1, 8'd3, "R4");
    ticks(2'd1, 8'd0, 6, "R4");
    step(3'd0, 7'h00, 2'd1, 8'd0, 0, 8'd0, 0, 0, 1, "R4");
    // R5 clear at compare, overflow only on 255 wrap
    wrCnt(2'd2, 8'd0, "R5");
    ticks(2'd2, 8'd4, 7, "R5");
    wrCnt(2'd2, 8'd253, "R5");
    ticks(2'd2, 8'd4, 4, "R5");
    step(3'd0, 7'h00, 2'd2, 8'd4, 0, 8'd0, 0, 0, 1, "R5");
    // R6 overflow on compare clear, R9 top follows compare
    wrCnt(2'd3, 8'd0, "R6");
    ticks(2'd3, 8'd3, 6, "R6");
    ticks(2'd3, 8'd0, 2, "R9");
    // R7 write beats tick at the wrap point
    step(3'd0, 7'h00, 2'd0, 8'd0, 0, 8'd0, 0, 0, 1, "R7");
    wrCnt(2'd0, 8'd255, "R7");
    step(3'd1, 7'h01, 2'd0, 8'd0, 1, 8'd100, 0, 0, 0, "R7");
    step(3'd1, 7'h01, 2'd0, 8'd0, 1, 8'd0, 0, 0, 0, "R7");
    // R8 write and hold while stopped
    wrCnt(2'd0, 8'd77, "R8");
    for (int i = 0; i < 3; i++) step(3'd0, 7'h00, 2'd0, 8'd0, 0, 8'd0, 0, 0, 0, "R8");
    wrCnt(2'd0, 8'd0, "R9");
    step(3'd0, 7'h00, 2'd0, 8'd0, 0, 8'd0, 0, 0, 0, "R9");
    repeat (3) @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule